// File: doc/BRIEF.md
# Command and Data Word Sequencer

This block is a register-mapped command engine. Software first writes a command code to the command address. It then streams 32-bit argument words to the data address. The sequencer stores each word in an argument buffer and counts the words. Each command code has its own argument length in bytes, and the sequencer checks the word count against that length after every write. When the words received, times four, reach the required length, it raises a one-cycle execute strobe. The strobe carries the command code and the argument buffer, and the bench returns a result code in the same cycle.

The outcome is kept in a status register that software reads back. The status shows "not enough data" while a command is still collecting arguments. It shows the result code once the command has run, or a failure code if no valid command was selected. A command that needs no arguments runs in the same write that selects it.

Top module: `cmd_word_sequencer`

## Requirements
- R1: A code written to the command address (byte offset 0x0) is accepted only if its full 32-bit value is greater than 0 and less than 10. Any other value selects the reserved code 0.
- R2: A command write clears the word counter and sets status to PENDING (0x0000_0001), unless that command runs in the same write.
- R3: A command whose argument length is zero raises exec_valid during the cycle of its own write, with exec_code equal to that code.
- R4: A write to the data address (byte offset 0x4) stores the word at the current counter position, word i occupying bits [32*i+31:32*i] of exec_args, and then increments the counter. The command runs once counter*4 >= its byte length, and status takes exec_result at the next clock edge.
- R5: The reserved code 0 needs zero bytes and always sets status to FAIL (0xFFFF_FFFF), whatever exec_result is. A data write with no pending command therefore leaves status at FAIL.
- R6: Argument lengths by code: 1 needs 24 bytes (6 words), 5 needs 8, 7 needs 16, 9 needs 12, 4 needs 48, and 2, 3, 6 and 8 need 0.
- R7: After a command runs, the current code returns to 0 and the counter returns to 0.
- R8: After reset, status reads OK (0x0000_0000), the counter is 0 and the current code is 0.
- R9: A data word that arrives when the counter already equals the buffer size (8 words) is dropped and the counter does not advance. Code 4 therefore never runs and its status stays PENDING.
- R10: exec_valid is high only during the cycle of the write that triggers the command, and for exactly one cycle per triggering write.
- R11: Status holds its value except on a command write or a command run. rd_data returns status at offset 0x8 and 0 at any other offset, and writes to any offset other than 0x0 or 0x4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 32 | Read data |
| exec_valid | output | 1 | Command execute strobe |
| exec_code | output | 8 | Code of the command being run |
| exec_args | output | 256 | Argument buffer, word 0 in the low bits |
| exec_result | input | 32 | Result code returned in the strobe cycle |

## Verification
The assertions assume that exec_result is valid and stable in the same cycle as exec_valid. The bench meets this by driving exec_result combinationally from exec_code. They also assume that each write lasts exactly one clock and that inputs do not change near the rising edge. The bench tasks drive every write on a falling edge for one cycle and release it on the next falling edge.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int CODE_W    = 8;
  localparam int LAST_CODE = 10;

  localparam logic [31:0] ST_OK      = 32'h0000_0000;
  localparam logic [31:0] ST_PENDING = 32'h0000_0001;
  localparam logic [31:0] ST_FAIL    = 32'hFFFF_FFFF;

  localparam logic [3:0] OFS_CMD    = 4'h0;
  localparam logic [3:0] OFS_DATA   = 4'h4;
  localparam logic [3:0] OFS_STATUS = 4'h8;

  // Argument length in bytes required by each command code
  function automatic logic [31:0] need_bytes(input logic [CODE_W-1:0] code);
    logic [31:0] n;
    case (code)
      8'd1:    n = 32'd24;
      8'd4:    n = 32'd48;
      8'd5:    n = 32'd8;
      8'd7:    n = 32'd16;
      8'd9:    n = 32'd12;
      default: n = 32'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/cws_argbuf.sv
module cws_argbuf #(
  parameter int ARG_WORDS = 8,
  parameter int CNT_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    store,
  input  logic [CNT_W-1:0]        store_idx,
  input  logic [31:0]             store_word,
  output logic [ARG_WORDS*32-1:0] args_nxt
);
  for (genvar g = 0; g < ARG_WORDS; g++) begin : g_word
    logic [31:0] word_q;
    logic        hit;

    assign hit = store && (store_idx == CNT_W'(g));
    // Merged view so a firing write sees its own word
    assign args_nxt[32*g +: 32] = hit ? store_word : word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= store_word;
    end
  end
endmodule

// File: rtl/cws_ctrl.sv
module cws_ctrl
  import cws_pkg::*;
#(
  parameter int ARG_WORDS = 8,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [CODE_W-1:0] sel_code,
  output logic              store,
  output logic [CNT_W-1:0]  store_idx,
  output logic              fire,
  output logic [CODE_W-1:0] fire_code,
  output logic [CODE_W-1:0] cur_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [CODE_W-1:0] cur_mid, cur_nxt;
  logic [CNT_W-1:0]  cnt_mid, cnt_nxt;
  logic              upd_en;

  assign upd_en    = cmd_wr || data_wr;
  assign store     = data_wr && (cnt_q < CNT_W'(ARG_WORDS));
  assign store_idx = cnt_q;

  always_comb begin
    cur_mid = cmd_wr ? sel_code : cur_q;
    cnt_mid = cmd_wr ? '0 : cnt_q;
    if (store) cnt_mid = cnt_q + CNT_W'(1);
    fire      = upd_en && ((32'(cnt_mid) * 32'd4) >= need_bytes(cur_mid));
    fire_code = cur_mid;
    cur_nxt   = fire ? '0 : cur_mid;
    cnt_nxt   = fire ? '0 : cnt_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      cur_q <= cur_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/cws_status.sv
module cws_status
  import cws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              fire,
  input  logic [CODE_W-1:0] fire_code,
  input  logic [31:0]       result,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       status_q,
  output logic [31:0]       rd_data
);
  logic [31:0] status_nxt;
  logic        st_en;

  assign st_en = fire || cmd_wr;

  always_comb begin
    if (fire)        status_nxt = (fire_code == '0) ? ST_FAIL : result;
    else if (cmd_wr) status_nxt = ST_PENDING;
    else             status_nxt = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= ST_OK;
    else if (st_en) status_q <= status_nxt;
  end

  assign rd_data = (rd_addr == OFS_STATUS) ? status_q : '0;
endmodule

// File: rtl/cmd_word_sequencer.sv
module cmd_word_sequencer
  import cws_pkg::*;
#(
  parameter int ARG_WORDS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [3:0]              wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [3:0]              rd_addr,
  output logic [31:0]             rd_data,
  output logic                    exec_valid,
  output logic [CODE_W-1:0]       exec_code,
  output logic [ARG_WORDS*32-1:0] exec_args,
  input  logic [31:0]             exec_result
);
  localparam int CNT_W = $clog2(ARG_WORDS + 1);

  logic              cmd_wr, data_wr, store, fire;
  logic [CODE_W-1:0] sel_code, fire_code, cur_q;
  logic [CNT_W-1:0]  store_idx, cnt_q;
  logic [31:0]       status_q;

  assign cmd_wr  = wr_en && (wr_addr == OFS_CMD);
  assign data_wr = wr_en && (wr_addr == OFS_DATA);
  assign sel_code = ((wr_data != 32'd0) && (wr_data < 32'(LAST_CODE)))
                    ? wr_data[CODE_W-1:0] : '0;

  cws_ctrl #(.ARG_WORDS(ARG_WORDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .sel_code(sel_code), .store(store), .store_idx(store_idx),
    .fire(fire), .fire_code(fire_code), .cur_q(cur_q), .cnt_q(cnt_q)
  );

  cws_argbuf #(.ARG_WORDS(ARG_WORDS), .CNT_W(CNT_W)) u_argbuf (
    .clk(clk), .rst_n(rst_n), .store(store), .store_idx(store_idx),
    .store_word(wr_data), .args_nxt(exec_args)
  );

  cws_status u_status (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .fire(fire),
    .fire_code(fire_code), .result(exec_result), .rd_addr(rd_addr),
    .status_q(status_q), .rd_data(rd_data)
  );

  assign exec_valid = fire;
  assign exec_code  = fire_code;
endmodule

// File: rtl/cws_checker.sv
module cws_checker
  import cws_pkg::*;
#(
  parameter int ARG_WORDS = 8,
  parameter int CNT_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic              exec_valid,
  input logic [CODE_W-1:0] exec_code,
  input logic [31:0]       exec_result,
  input logic [31:0]       status_q,
  input logic [CODE_W-1:0] cur_q,
  input logic [CNT_W-1:0]  cnt_q
);
  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (exec_code < CODE_W'(LAST_CODE)));  // R1
  AST_PENDING_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_CMD && !exec_valid) |=> (status_q == ST_PENDING));  // R2
  AST_RESULT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_code != '0) |=> (status_q == $past(exec_result)));  // R4
  AST_RESERVED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_code == '0) |=> (status_q == ST_FAIL));  // R5
  AST_RETURN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |=> (cnt_q == '0 && cur_q == '0));  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ARG_WORDS));  // R9
  AST_STROBE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (wr_en && (wr_addr == OFS_CMD || wr_addr == OFS_DATA)));  // R10
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(status_q));  // R11
endmodule

bind cmd_word_sequencer cws_checker #(.ARG_WORDS(ARG_WORDS), .CNT_W(CNT_W)) u_cws_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .exec_valid(exec_valid), .exec_code(exec_code), .exec_result(exec_result),
  .status_q(status_q), .cur_q(cur_q), .cnt_q(cnt_q)
);

// File: tb/tb_cmd_word_sequencer.sv
module tb_cmd_word_sequencer;
  localparam int CLK_P = 10;
  localparam int AW    = 8;

  logic          clk, rst_n, wr_en;
  logic [3:0]    wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data, exec_result;
  logic          exec_valid;
  logic [7:0]    exec_code;
  logic [AW*32-1:0] exec_args;

  int checks = 0, fails = 0, pulses = 0;
  logic          l_exec;
  logic [7:0]    l_code;
  logic [AW*32-1:0] l_args;

  cmd_word_sequencer #(.ARG_WORDS(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .exec_valid(exec_valid), .exec_code(exec_code), .exec_args(exec_args),
    .exec_result(exec_result)
  );

  assign exec_result = 32'h5A00_0000 | {24'd0, exec_code};

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (rst_n && exec_valid) pulses++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; one-cycle write, returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    l_exec = exec_valid; l_code = exec_code; l_args = exec_args;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic status_is(input logic [31:0] exp, input string tag);
    rd_addr = 4'h8; #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic t_reset;
    status_is(32'h0, "R8 status OK after reset");
    wr(4'h4, 32'h1234);
    chk(l_exec && l_code == 8'd0, "R8 R5 stray data runs reserved", {24'd0, l_code}, 32'd0);
    status_is(32'hFFFF_FFFF, "R5 R7 stray data gives FAIL");
  endtask

  task automatic t_zero_len;
    logic [7:0] codes [4] = '{8'd2, 8'd3, 8'd6, 8'd8};
    for (int i = 0; i < 4; i++) begin
      wr(4'h0, {24'd0, codes[i]});
      chk(l_exec && l_code == codes[i], "R3 R6 zero-length runs on command write",
          {24'd0, l_code}, {24'd0, codes[i]});
      status_is(32'h5A00_0000 | {24'd0, codes[i]}, "R3 status takes result");
    end
  endtask

  task automatic t_config;
    wr(4'h0, 32'd1);
    chk(!l_exec, "R2 config does not run on command write", {31'd0, l_exec}, 32'd0);
    status_is(32'h1, "R2 PENDING after command");
    for (int i = 0; i < 5; i++) begin
      wr(4'h4, 32'h100 + i);
      chk(!l_exec, "R6 config waits for 6 words", {31'd0, l_exec}, 32'd0);
    end
    status_is(32'h1, "R4 still PENDING at 5 words");
    wr(4'h4, 32'h105);
    chk(l_exec && l_code == 8'd1, "R4 config runs on 6th word", {24'd0, l_code}, 32'd1);
    for (int i = 0; i < 6; i++)
      chk(l_args[32*i +: 32] == 32'h100 + i, "R4 argument word position",
          l_args[32*i +: 32], 32'h100 + i);
    status_is(32'h5A00_0001, "R4 status takes result");
    wr(4'h4, 32'h7);
    chk(l_exec && l_code == 8'd0, "R7 back to reserved after run", {24'd0, l_code}, 32'd0);
    status_is(32'hFFFF_FFFF, "R7 FAIL after stray word");
  endtask

  task automatic t_range;
    wr(4'h0, 32'd0);
    chk(l_exec && l_code == 8'd0, "R1 code 0 is reserved", {24'd0, l_code}, 32'd0);
    status_is(32'hFFFF_FFFF, "R1 R5 code 0 fails");
    wr(4'h0, 32'd10);
    chk(l_exec && l_code == 8'd0, "R1 code 10 rejected", {24'd0, l_code}, 32'd0);
    wr(4'h0, 32'h0001_0006);
    chk(l_exec && l_code == 8'd0, "R1 upper bits rejected", {24'd0, l_code}, 32'd0);
    status_is(32'hFFFF_FFFF, "R1 rejected code fails");
    wr(4'h0, 32'd9);
    status_is(32'h1, "R1 code 9 accepted");
    wr(4'h4, 32'hA); wr(4'h4, 32'hB);
    chk(!l_exec, "R6 abort waits for 3 words", {31'd0, l_exec}, 32'd0);
    wr(4'h4, 32'hC);
    chk(l_exec && l_code == 8'd9, "R6 abort runs on 3rd word", {24'd0, l_code}, 32'd9);
  endtask

  task automatic t_restart;
    wr(4'h0, 32'd1);
    wr(4'h4, 32'h11); wr(4'h4, 32'h22); wr(4'h4, 32'h33);
    wr(4'h0, 32'd5);
    status_is(32'h1, "R2 new command restarts");
    wr(4'h4, 32'h44);
    chk(!l_exec, "R2 counter cleared by command", {31'd0, l_exec}, 32'd0);
    wr(4'h4, 32'h55);
    chk(l_exec && l_code == 8'd5, "R2 R6 unit reset runs on 2nd word", {24'd0, l_code}, 32'd5);
    chk(l_args[31:0] == 32'h44 && l_args[63:32] == 32'h55, "R2 words restart at 0",
        l_args[31:0], 32'h44);
  endtask

  task automatic t_overflow;
    wr(4'h0, 32'd4);
    for (int i = 0; i < 12; i++) begin
      wr(4'h4, 32'h900 + i);
      chk(!l_exec, "R9 oversize command never runs", {31'd0, l_exec}, 32'd0);
    end
    status_is(32'h1, "R9 status stays PENDING");
    wr(4'h0, 32'd7);
    for (int i = 0; i < 4; i++) wr(4'h4, 32'h700 + i);
    chk(l_exec && l_code == 8'd7, "R6 msg init runs on 4th word", {24'd0, l_code}, 32'd7);
    for (int i = 4; i < 8; i++)
      chk(l_args[32*i +: 32] == 32'h900 + i, "R9 words past capacity dropped",
          l_args[32*i +: 32], 32'h900 + i);
  endtask

  task automatic t_ignore;
    int p0;
    p0 = pulses;
    wr(4'h0, 32'd1);
    wr(4'hC, 32'd6); wr(4'h8, 32'd6);
    chk(!l_exec, "R11 other offsets ignored", {31'd0, l_exec}, 32'd0);
    status_is(32'h1, "R11 status held");
    rd_addr = 4'hC; #1;
    chk(rd_data == 32'h0, "R11 other read offset gives 0", rd_data, 32'h0);
    repeat (3) @(negedge clk);
    status_is(32'h1, "R11 status held while idle");
    for (int i = 0; i < 6; i++) wr(4'h4, 32'h1);
    chk(pulses - p0 == 1, "R10 one strobe per triggering write", pulses - p0, 32'd1);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 4'h8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_zero_len;
    t_config;
    t_range;
    t_restart;
    t_overflow;
    t_ignore;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule